// File: doc/BRIEF.md
# Eight-bit timer/counter with a shared prescaler

This block holds an 8-bit count register that software loads and reads back. The register advances either once per instruction cycle (one `clk` period) or on a chosen edge of an external clock pin. An external pin is first passed through a two-flop synchroniser and then through an edge detector. A single 8-bit prescaler sits either in front of the count register or behind the watchdog clock input, and never in both places. A 3-bit ratio code picks one of the prescaler's eight taps. When the count rolls from FFh to 00h, a sticky overflow flag is set, and an interrupt request is raised while the flag and the enable input are both high.

A write to the count register starts a short stall, handled by a three-state machine. In `HOLD_RUN` the counter may advance. A write (transition *load*) moves it to `HOLD_ONE`. The next cycle (transition *settle*) moves it to `HOLD_TWO`. The cycle after that (transition *release*) returns it to `HOLD_RUN`. A write that arrives while in `HOLD_ONE` or `HOLD_TWO` (transition *reload*) sends it back to `HOLD_ONE`. Count events are dropped in the write cycle and in both hold states, and they do not reach the prescaler.

Top module: `tmr_top`

## Requirements
- R1: Reset clears the count and the flag and drives `irq` and `wdt_tick` low. It also sets the control register to zero: internal source, rising edge, prescaler on the counter, ratio 1:2. After reset is released the count therefore reads 1 after the second clock edge and 2 after the fourth.
- R2: When `cnt_wr` is high at a clock edge, `cnt_q` shows `cnt_wdata` after that edge. When `ctl_wr` is high, the control register loads `ctl_wdata`, where bit 5 selects the source (1 = external pin), bit 4 selects the edge (1 = falling), bit 3 assigns the prescaler (1 = watchdog) and bits 2:0 hold the ratio code.
- R3: With the internal source and the prescaler on the watchdog, the count rises by one at every clock edge and wraps from FFh to 00h.
- R4: After the edge that performs a write, the count holds the written value for two further edges, so the first increment lands on the third edge after the write.
- R5: With the external source and the rising edge selected, a rising edge on `ext_clk` that is applied between clock edges makes the count rise at the third clock edge that follows.
- R6: With the falling edge selected, only falling edges of `ext_clk` advance the count, and with the same three-edge latency. Rising edges have no effect.
- R7: An increment from FFh sets `ovf_flag`. The flag stays set until `flag_clr` is sampled high. When an overflow and `flag_clr` fall on the same edge, the flag ends up set.
- R8: A write to the count takes priority over an increment on the same edge. That edge loads the written value and cannot set the flag.
- R9: `irq` is high exactly while `ovf_flag` and `irq_en` are both high.
- R10: With the prescaler on the counter, ratio code k makes the count advance once per 2^(k+1) source events, for codes 0 to 7 (1:2 to 1:256).
- R11: With the prescaler on the watchdog, `wdt_tick` pulses once per 2^k cycles in which `wdt_clk` is high (1:1 to 1:128). With the prescaler on the counter, `wdt_tick` repeats `wdt_clk` one cycle later.
- R12: A count write while the prescaler is on the counter restarts the prescaler from zero and keeps the ratio code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 8 | Value to load into the count register |
| cnt_q | output | 8 | Current count |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 6 | Control value: source, edge, prescaler assignment, ratio code |
| ext_clk | input | 1 | External count input, asynchronous to `clk` |
| flag_clr | input | 1 | Clears the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| wdt_clk | input | 1 | Watchdog clock pulses, one per cycle while high |
| wdt_tick | output | 1 | Registered tick towards the watchdog |

## Verification
Two pairs of actions can fall on the same clock edge. The first pair is a rollover from FFh and a software clear of the flag. The bench loads FCh, waits until the count reads FFh, and raises `flag_clr` just before the edge that wraps the count. It then checks that the flag reads set after that edge and reads clear only one edge later. The second pair is a count write and a rollover: the bench writes a new value exactly on the edge where FFh would wrap, and checks that the written value appears with the flag still clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int RATIO_W = 3;
    localparam int PRE_W   = 1 << RATIO_W;
    localparam int CTL_W   = RATIO_W + 3;

    typedef enum logic [1:0] {
        HOLD_RUN = 2'd0,
        HOLD_ONE = 2'd1,
        HOLD_TWO = 2'd2
    } hold_state_t;

    typedef struct packed {
        logic               src_ext;
        logic               edge_fall;
        logic               pre_wdt;
        logic [RATIO_W-1:0] ratio;
    } tmr_ctl_t;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic fall_sel,
    output logic pulse
);
    logic [STAGES-1:0] stage_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 1'b0;
            else        stage_q[i] <= stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= stage_q[STAGES-1];
    end

    logic rise, fall;
    assign rise  = stage_q[STAGES-1] & ~last_q;
    assign fall  = ~stage_q[STAGES-1] & last_q;
    assign pulse = fall_sel ? fall : rise;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W     = 8,
    parameter int SEL_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic             to_wdt,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [W-1:0]     pcnt;
    logic [W-1:0]     full;
    logic [SEL_W-1:0] sel_m1;
    logic             hit_ctr, hit_wdt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pcnt <= '0;
        else if (clr) pcnt <= '0;
        else if (evt) pcnt <= pcnt + W'(1);
    end

    for (genvar i = 0; i < W; i++) begin : g_tap
        assign full[i] = &pcnt[i:0];
    end

    assign sel_m1  = sel - SEL_W'(1);
    assign hit_ctr = full[sel];
    assign hit_wdt = (sel == '0) ? 1'b1 : full[sel_m1];
    assign tick    = evt & (to_wdt ? hit_wdt : hit_ctr);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         inc,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic         flag,
    output logic         run
);
    hold_state_t state_q, state_d;
    logic        inc_ok, wrap;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_RUN: state_d = wr_en ? HOLD_ONE : HOLD_RUN;
            HOLD_ONE: state_d = wr_en ? HOLD_ONE : HOLD_TWO;
            HOLD_TWO: state_d = wr_en ? HOLD_ONE : HOLD_RUN;
            default:  state_d = HOLD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        run = 1'b0;
        unique case (state_q)
            HOLD_RUN: run = ~wr_en;
            HOLD_ONE: run = 1'b0;
            HOLD_TWO: run = 1'b0;
            default:  run = 1'b0;
        endcase
    end

    assign inc_ok = inc & run;
    assign wrap   = inc_ok & (cnt == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (wr_en)  cnt <= wr_data;
        else if (inc_ok) cnt <= cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             ext_clk,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic             ovf_flag,
    output logic             irq,
    input  logic             wdt_clk,
    output logic             wdt_tick
);
    tmr_ctl_t ctl_q, ctl_in;
    logic     next_to_wdt;
    logic     ext_edge, run, src_evt, presc_evt, presc_clr, presc_tick, cnt_inc;

    assign ctl_in = tmr_ctl_t'(ctl_wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_in;
    end

    assign next_to_wdt = ctl_wr ? ctl_in.pre_wdt : ctl_q.pre_wdt;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (ext_clk),
        .fall_sel (ctl_q.edge_fall),
        .pulse    (ext_edge)
    );

    assign src_evt   = run & (ctl_q.src_ext ? ext_edge : 1'b1);
    assign presc_evt = ctl_q.pre_wdt ? wdt_clk : src_evt;
    assign presc_clr = cnt_wr & ~next_to_wdt;

    tmr_prescaler #(.W(PRE_W), .SEL_W(RATIO_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (presc_clr),
        .evt    (presc_evt),
        .to_wdt (ctl_q.pre_wdt),
        .sel    (ctl_q.ratio),
        .tick   (presc_tick)
    );

    assign cnt_inc = ctl_q.pre_wdt ? src_evt : presc_tick;

    tmr_count_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cnt_wr),
        .wr_data  (cnt_wdata),
        .inc      (cnt_inc),
        .flag_clr (flag_clr),
        .cnt      (cnt_q),
        .flag     (ovf_flag),
        .run      (run)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wdt_tick <= 1'b0;
        else        wdt_tick <= ctl_q.pre_wdt ? presc_tick : wdt_clk;
    end

    assign irq = ovf_flag & irq_en;

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_wr,
    input logic [W-1:0] cnt_wdata,
    input logic [W-1:0] cnt_q,
    input logic         flag_clr,
    input logic         irq_en,
    input logic         ovf_flag,
    input logic         irq
);
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(cnt_wdata));

    a_r4_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && $past(cnt_wr)) |=> $stable(cnt_q));

    a_r4_hold_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !$past(cnt_wr) && $past(cnt_wr, 2)) |=> $stable(cnt_q));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && cnt_q == '1) |=> (cnt_q == '1 || ovf_flag));

    a_r8_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && flag_clr) |=> !ovf_flag);

    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

endmodule

bind tmr_top tmr_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .cnt_q     (cnt_q),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .ovf_flag  (ovf_flag),
    .irq       (irq)
);

// File: tb/sim_tmr_top.sv
module sim_tmr_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = 8'h00;
    logic [7:0] cnt_q;
    logic       ctl_wr = 1'b0;
    logic [5:0] ctl_wdata = 6'h00;
    logic       ext_clk = 1'b0;
    logic       flag_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       ovf_flag, irq;
    logic       wdt_clk = 1'b0;
    logic       wdt_tick;

    tmr_top u0 (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt_q(cnt_q), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ext_clk(ext_clk),
        .flag_clr(flag_clr), .irq_en(irq_en), .ovf_flag(ovf_flag), .irq(irq),
        .wdt_clk(wdt_clk), .wdt_tick(wdt_tick)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int checks = 0;
    int fails  = 0;
    bit wd_fired = 0;

    typedef struct {
        int    cyc;
        int    kind;
        int    val;
        string tag;
    } item_t;
    item_t sb[$];

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int probe(int kind);
        case (kind)
            0:       return int'(cnt_q);
            1:       return int'(ovf_flag);
            2:       return int'(irq);
            default: return int'(wdt_tick);
        endcase
    endfunction

    task automatic expect_at(int c, int kind, int val, string tag);
        item_t it;
        int    i = 0;
        it.cyc = c; it.kind = kind; it.val = val & 255; it.tag = tag;
        while (i < sb.size() && sb[i].cyc <= c) i++;
        sb.insert(i, it);
    endtask

    always begin
        @(negedge clk);
        #1;
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.cyc < cyc) chk({it.tag, " missed sample"}, it.cyc, cyc);
            else              chk(it.tag, probe(it.kind), it.val);
        end
    end

    function automatic logic [5:0] mk(logic src, logic fall, logic wdt, int r);
        logic [2:0] rr;
        rr = 3'(r);
        return {src, fall, wdt, rr};
    endfunction

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic start_write(logic [7:0] d, logic set_ctl, logic [5:0] c, output int n);
        repeat (4) @(negedge clk);
        n         = cyc;
        cnt_wr    = 1'b1;
        cnt_wdata = d;
        ctl_wr    = set_ctl;
        ctl_wdata = c;
        flag_clr  = 1'b1;
        @(negedge clk);
        cnt_wr    = 1'b0;
        ctl_wr    = 1'b0;
        flag_clr  = 1'b0;
    endtask

    task automatic run_all();
        int n, k, cnt;

        // R1: reset state and default control value
        repeat (3) @(negedge clk);
        #1;
        chk("R1 count in reset", int'(cnt_q), 0);
        chk("R1 flag in reset", int'(ovf_flag), 0);
        chk("R1 irq in reset", int'(irq), 0);
        chk("R1 wdt_tick in reset", int'(wdt_tick), 0);
        rst_n = 1'b1;
        n = cyc;
        expect_at(n + 1, 0, 0, "R1 default 1:2 first edge");
        expect_at(n + 2, 0, 1, "R1 default 1:2 second edge");
        expect_at(n + 3, 0, 1, "R1 default 1:2 third edge");
        expect_at(n + 4, 0, 2, "R1 default 1:2 fourth edge");
        drain();

        // R3, R4, R7, R9: undivided timer through a wrap
        irq_en = 1'b1;
        start_write(8'hF0, 1'b1, mk(1'b0, 1'b0, 1'b1, 0), n);
        for (int c = 1; c <= 3; c++) expect_at(n + c, 0, 8'hF0, "R4 stall after write");
        for (int c = 4; c <= 22; c++) expect_at(n + c, 0, 8'hF0 + c - 3, "R3 count per cycle");
        expect_at(n + 18, 1, 0, "R7 flag before wrap");
        expect_at(n + 19, 1, 1, "R7 flag on wrap");
        expect_at(n + 18, 2, 0, "R9 irq before wrap");
        expect_at(n + 19, 2, 1, "R9 irq on wrap");
        drain();

        // R9 mask and R7 stickiness
        @(negedge clk);
        irq_en = 1'b0;
        #1;
        chk("R9 irq masked", int'(irq), 0);
        chk("R7 flag kept", int'(ovf_flag), 1);
        repeat (5) @(negedge clk);
        #1;
        chk("R7 flag still kept", int'(ovf_flag), 1);
        irq_en = 1'b1;
        #1;
        chk("R9 irq unmasked", int'(irq), 1);

        // R7: overflow and clear on the same edge
        start_write(8'hFC, 1'b0, 6'h00, n);
        expect_at(n + 6, 0, 8'hFF, "R7 reached FF");
        expect_at(n + 6, 1, 0, "R7 flag cleared by write cycle");
        expect_at(n + 7, 0, 8'h00, "R7 wrapped");
        expect_at(n + 7, 1, 1, "R7 set wins over clear");
        expect_at(n + 8, 1, 0, "R7 clear next edge");
        wait_until(n + 6);
        flag_clr = 1'b1;
        wait_until(n + 8);
        flag_clr = 1'b0;
        drain();

        // R8: write on the wrapping edge
        start_write(8'hFD, 1'b0, 6'h00, n);
        expect_at(n + 5, 0, 8'hFF, "R8 at FF");
        expect_at(n + 6, 0, 8'h10, "R8 write wins");
        expect_at(n + 6, 1, 0, "R8 no flag");
        expect_at(n + 7, 1, 0, "R8 no flag later");
        expect_at(n + 8, 0, 8'h10, "R8 stall after second write");
        expect_at(n + 9, 0, 8'h11, "R8 resumes");
        wait_until(n + 5);
        cnt_wr = 1'b1;
        cnt_wdata = 8'h10;
        wait_until(n + 6);
        cnt_wr = 1'b0;
        drain();

        // R5 and R7: rising external edges through a wrap
        start_write(8'hFD, 1'b1, mk(1'b1, 1'b0, 1'b1, 0), n);
        for (int i = 0; i < 5; i++) begin
            expect_at(n + 6 + 4 * i, 0, 8'hFD + i, "R5 before rising edge");
            expect_at(n + 7 + 4 * i, 0, 8'hFD + i + 1, "R5 after rising edge");
        end
        expect_at(n + 14, 1, 0, "R7 counter mode before wrap");
        expect_at(n + 15, 1, 1, "R7 counter mode wrap");
        for (int i = 0; i < 5; i++) begin
            wait_until(n + 4 + 4 * i);
            ext_clk = 1'b1;
            wait_until(n + 6 + 4 * i);
            ext_clk = 1'b0;
        end
        drain();

        // R6: falling edges only
        start_write(8'h40, 1'b1, mk(1'b1, 1'b1, 1'b1, 0), n);
        for (int i = 0; i < 5; i++) begin
            expect_at(n + 7 + 4 * i, 0, 8'h40 + i, "R6 rising edge ignored");
            expect_at(n + 8 + 4 * i, 0, 8'h40 + i, "R6 before falling edge");
            expect_at(n + 9 + 4 * i, 0, 8'h40 + i + 1, "R6 after falling edge");
        end
        for (int i = 0; i < 5; i++) begin
            wait_until(n + 4 + 4 * i);
            ext_clk = 1'b1;
            wait_until(n + 6 + 4 * i);
            ext_clk = 1'b0;
        end
        drain();

        // R10: every ratio with the prescaler on the counter; R11 pass-through
        wdt_clk = 1'b1;
        for (int r = 0; r < 8; r++) begin
            int rt;
            rt = 2 << r;
            start_write(8'h00, 1'b1, mk(1'b0, 1'b0, 1'b0, r), n);
            expect_at(n + 2 + rt, 0, 0, "R10 before first tick");
            expect_at(n + 3 + rt, 0, 1, "R10 first tick");
            expect_at(n + 3 + 2 * rt, 0, 2, "R10 second tick");
            if (r == 0) expect_at(n + 3, 3, 1, "R11 wdt_clk passed through");
            drain();
        end
        @(negedge clk);
        wdt_clk = 1'b0;
        #1;
        chk("R11 pass-through registered", int'(wdt_tick), 1);
        @(negedge clk);
        #1;
        chk("R11 pass-through follows low", int'(wdt_tick), 0);

        // R12: count write restarts the prescaler, ratio kept
        start_write(8'h00, 1'b1, mk(1'b0, 1'b0, 1'b0, 2), n);
        expect_at(n + 11, 0, 1, "R12 ratio 1:8 before rewrite");
        k = n + 16;
        expect_at(k + 10, 0, 8'h20, "R12 prescaler restarted");
        expect_at(k + 11, 0, 8'h21, "R12 first tick after rewrite");
        expect_at(k + 19, 0, 8'h22, "R12 ratio unchanged");
        wait_until(k);
        cnt_wr = 1'b1;
        cnt_wdata = 8'h20;
        wait_until(k + 1);
        cnt_wr = 1'b0;
        drain();

        // R11: every ratio with the prescaler on the watchdog
        wdt_clk = 1'b1;
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            ctl_wr = 1'b1;
            ctl_wdata = mk(1'b0, 1'b0, 1'b1, r);
            @(negedge clk);
            ctl_wr = 1'b0;
            repeat (300) @(negedge clk);
            cnt = 0;
            repeat (4 << r) begin
                @(negedge clk);
                #1;
                if (wdt_tick) cnt++;
            end
            chk($sformatf("R11 watchdog ticks at code %0d", r), cnt, 4);
        end
        wdt_clk = 1'b0;
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule